// File: doc/BRIEF.md
# Configurable Buffer and Decode Logic Cell

This cell takes ten single-bit inputs and treats them as three groups: a low nibble (bits 3:0), a high nibble (bits 7:4) and a two-bit control pair (bits 9:8). Static configuration inputs decide, for each group separately, whether its bits pass through as buffered outputs or feed a small decode tree. Each nibble's output-enable comes from one shared tri-state control, used as is or inverted, or it is switched off. It can also come from the cell's own decode result. That last option gives the two nibbles independent enables.

In the decode tree, each group selected for decoding feeds its own AND gate. The three group terms meet in one three-input gate, which is set to AND or to OR. Its result can be inverted before it reaches the decode output. When all three groups are buffers, the decode output can instead carry a configured constant. Before any of this, configuration can force any input to a fixed 0 or 1. Tri-state pins are modelled as a data vector plus per-bit enables. All outputs are registered once, so they show the inputs of the previous clock edge.

Top module: `bdc_cell`

## Requirements
- R1: When `force_en[k]` is 1, input bit k is replaced by `force_val[k]` before it reaches the buffers and the AND gates. When it is 0, `din[k]` is used.
- R2: `buf_out[k]` equals the conditioned bit k one clock after it is presented, for all ten bits.
- R3: A nibble in buffer mode drives all four of its enable bits (`nib_oe[3:0]` for the low nibble, `nib_oe[7:4]` for the high nibble) from its 2-bit mode: 00 gives 0, 01 gives `tri_ctl`, and 10 gives the inverse of `tri_ctl`.
- R4: Mode 11 drives the nibble's four enable bits with the decode value computed in the same cycle, so `nib_oe` matches `dec_out` in the same output cycle.
- R5: A nibble whose `grp_dec` bit is 1 (decode mode) drives its enable bits to 0, whatever its enable mode is.
- R6: A group in decode mode (`grp_dec[0]` low nibble, `grp_dec[1]` high nibble, `grp_dec[2]` pair) contributes the AND of its conditioned bits. The three group terms are combined by AND when `comb_or` is 0 and by OR when `comb_or` is 1.
- R7: A group in buffer mode contributes 1 to an AND combination and 0 to an OR combination, so it does not change the result.
- R8: When `dec_inv` is 1, the combined value is inverted before it reaches `dec_out`.
- R9: When `grp_dec` is 000 and `const_en` is 1, `dec_out` equals `const_val`, with no inversion applied. When any group decodes, `const_en` has no effect.
- R10: While `rst_n` is low, `buf_out`, `nib_oe` and `dec_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 10 | Cell inputs: [3:0] low nibble, [7:4] high nibble, [9:8] pair |
| tri_ctl | input | 1 | Shared tri-state control |
| force_en | input | 10 | Per-bit constant override enable |
| force_val | input | 10 | Per-bit constant override value |
| grp_dec | input | 3 | Per-group decode select (1 = decode) |
| oe_mode0 | input | 2 | Low nibble enable source |
| oe_mode1 | input | 2 | High nibble enable source |
| comb_or | input | 1 | Combining gate: 0 = AND, 1 = OR |
| dec_inv | input | 1 | Invert the combined decode value |
| const_en | input | 1 | Constant decode output when all groups buffer |
| const_val | input | 1 | Constant decode value |
| buf_out | output | 10 | Registered buffered data |
| nib_oe | output | 8 | Registered per-bit enables of both nibbles |
| dec_out | output | 1 | Registered decode output |

## Verification
Every tested configuration is swept over all 1024 input patterns. This exposes a decode tree that lets a buffered group leak into the result: such a design would give the wrong `dec_out` on the patterns where that group's bits are not all 1 (under AND) or are all 1 (under OR). Further configurations set the enable modes against decode selection, where an enable left active while its nibble decodes would show raised `nib_oe` bits. They also request the constant while some group decodes, where a cell that obeys `const_en` there would give a flat `dec_out`. The enable-from-decode mode is checked for an off-by-one-cycle skew against `dec_out`. Forced inputs are checked to reach both the buffers and the AND gates.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
    parameter int NIB_W   = 4;
    parameter int NUM_NIB = 2;
    parameter int PAIR_W  = 2;
    localparam int IN_W   = NUM_NIB * NIB_W + PAIR_W;
    localparam int OE_W   = NUM_NIB * NIB_W;
    localparam int NUM_GRP = NUM_NIB + 1;

    typedef enum logic [1:0] {
        OE_OFF   = 2'b00,
        OE_TRI   = 2'b01,
        OE_TRI_N = 2'b10,
        OE_DEC   = 2'b11
    } oe_sel_e;

    typedef struct packed {
        logic [IN_W-1:0] data;
        logic [OE_W-1:0] oe;
        logic            dec;
    } cell_state_t;
endpackage

// File: rtl/bdc_in_cond.sv
module bdc_in_cond #(
    parameter int WIDTH = 10
) (
    input  logic [WIDTH-1:0] raw,
    input  logic [WIDTH-1:0] force_en,
    input  logic [WIDTH-1:0] force_val,
    output logic [WIDTH-1:0] cond
);
    for (genvar k = 0; k < WIDTH; k++) begin : g_bit
        always_comb begin
            cond[k] = force_en[k] ? force_val[k] : raw[k];
        end
    end
endmodule

// File: rtl/bdc_group_term.sv
module bdc_group_term #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] bits,
    input  logic             sel,
    input  logic             comb_or,
    output logic             term
);
    logic and_v;
    always_comb begin
        and_v = &bits;
        if (sel) term = and_v;
        else     term = ~comb_or;   // neutral element of the combining gate
    end
endmodule

// File: rtl/bdc_combine.sv
module bdc_combine #(
    parameter int NTERM = 3
) (
    input  logic [NTERM-1:0] terms,
    input  logic             any_sel,
    input  logic             comb_or,
    input  logic             dec_inv,
    input  logic             const_en,
    input  logic             const_val,
    output logic             dec
);
    logic gate_v;
    always_comb begin
        gate_v = comb_or ? (|terms) : (&terms);
        if (!any_sel && const_en) dec = const_val;
        else                      dec = gate_v ^ dec_inv;
    end
endmodule

// File: rtl/bdc_cell.sv
module bdc_cell
    import bdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IN_W-1:0]   din,
    input  logic              tri_ctl,
    input  logic [IN_W-1:0]   force_en,
    input  logic [IN_W-1:0]   force_val,
    input  logic [NUM_GRP-1:0] grp_dec,
    input  logic [1:0]        oe_mode0,
    input  logic [1:0]        oe_mode1,
    input  logic              comb_or,
    input  logic              dec_inv,
    input  logic              const_en,
    input  logic              const_val,
    output logic [IN_W-1:0]   buf_out,
    output logic [OE_W-1:0]   nib_oe,
    output logic              dec_out
);
    logic [IN_W-1:0]    cond;
    logic [NUM_GRP-1:0] terms;
    logic               dec_c;
    oe_sel_e            oe_sel [NUM_NIB];
    cell_state_t        st_d, st_q;

    assign oe_sel[0] = oe_sel_e'(oe_mode0);
    assign oe_sel[1] = oe_sel_e'(oe_mode1);

    bdc_in_cond #(.WIDTH(IN_W)) u_cond (
        .raw(din), .force_en(force_en), .force_val(force_val), .cond(cond)
    );

    for (genvar g = 0; g < NUM_NIB; g++) begin : g_nib
        bdc_group_term #(.WIDTH(NIB_W)) u_term (
            .bits(cond[g*NIB_W +: NIB_W]), .sel(grp_dec[g]),
            .comb_or(comb_or), .term(terms[g])
        );
    end

    bdc_group_term #(.WIDTH(PAIR_W)) u_pair (
        .bits(cond[IN_W-1 -: PAIR_W]), .sel(grp_dec[NUM_GRP-1]),
        .comb_or(comb_or), .term(terms[NUM_GRP-1])
    );

    bdc_combine #(.NTERM(NUM_GRP)) u_comb (
        .terms(terms), .any_sel(|grp_dec), .comb_or(comb_or),
        .dec_inv(dec_inv), .const_en(const_en), .const_val(const_val),
        .dec(dec_c)
    );

    always_comb begin
        st_d      = st_q;
        st_d.data = cond;
        st_d.dec  = dec_c;
        for (int g = 0; g < NUM_NIB; g++) begin
            logic en;
            if (grp_dec[g]) en = 1'b0;
            else begin
                unique case (oe_sel[g])
                    OE_OFF:   en = 1'b0;
                    OE_TRI:   en = tri_ctl;
                    OE_TRI_N: en = ~tri_ctl;
                    default:  en = dec_c;
                endcase
            end
            st_d.oe[g*NIB_W +: NIB_W] = {NIB_W{en}};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign buf_out = st_q.data;
    assign nib_oe  = st_q.oe;
    assign dec_out = st_q.dec;
endmodule

// File: rtl/bdc_cell_chk.sv
module bdc_cell_chk
    import bdc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tri_ctl,
    input logic [IN_W-1:0]   force_en,
    input logic [IN_W-1:0]   force_val,
    input logic [NUM_GRP-1:0] grp_dec,
    input logic [1:0]        oe_mode0,
    input logic [1:0]        oe_mode1,
    input logic              const_en,
    input logic              const_val,
    input logic [IN_W-1:0]   buf_out,
    input logic [OE_W-1:0]   nib_oe,
    input logic              dec_out
);
    // R1
    all_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_en == '1) |=> (buf_out == $past(force_val)));

    // R3
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!grp_dec[0] && oe_mode0 == 2'b00) |=> (nib_oe[3:0] == 4'h0));

    // R3
    oe_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!grp_dec[1] && oe_mode1 == 2'b01) |=> (nib_oe[7:4] == {4{$past(tri_ctl)}}));

    // R4
    oe_from_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!grp_dec[1] && oe_mode1 == 2'b11) |=> (nib_oe[7:4] == {4{dec_out}}));

    // R5
    dec_nib_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_dec[0] |=> (nib_oe[3:0] == 4'h0));

    // R9
    const_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_dec == '0 && const_en) |=> (dec_out == $past(const_val)));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (buf_out == '0 && nib_oe == '0 && !dec_out));
endmodule

bind bdc_cell bdc_cell_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tri_ctl(tri_ctl), .force_en(force_en),
    .force_val(force_val), .grp_dec(grp_dec), .oe_mode0(oe_mode0),
    .oe_mode1(oe_mode1), .const_en(const_en), .const_val(const_val),
    .buf_out(buf_out), .nib_oe(nib_oe), .dec_out(dec_out)
);

// File: tb/bdc_cell_tb.sv
`timescale 1ns/1ps
module bdc_cell_tb;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [9:0] din = '0;
    logic       tri_ctl = 0;
    logic [9:0] force_en = '0, force_val = '0;
    logic [2:0] grp_dec = '0;
    logic [1:0] oe_mode0 = '0, oe_mode1 = '0;
    logic       comb_or = 0, dec_inv = 0, const_en = 0, const_val = 0;
    logic [9:0] buf_out;
    logic [7:0] nib_oe;
    logic       dec_out;

    int compared = 0, mismatched = 0;
    bit done = 0;

    typedef struct {
        logic [9:0] data;
        logic [7:0] oe;
        logic       dec;
        string      tag_data;
        string      tag_oe;
        string      tag_dec;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    bdc_cell u_dut (
        .clk(clk), .rst_n(rst_n), .din(din), .tri_ctl(tri_ctl),
        .force_en(force_en), .force_val(force_val), .grp_dec(grp_dec),
        .oe_mode0(oe_mode0), .oe_mode1(oe_mode1), .comb_or(comb_or),
        .dec_inv(dec_inv), .const_en(const_en), .const_val(const_val),
        .buf_out(buf_out), .nib_oe(nib_oe), .dec_out(dec_out)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Expected-value model, written from the requirement list
    function automatic exp_t model(string td, string to, string tdc);
        exp_t e;
        logic [9:0] c;
        logic t0, t1, t2, g, dv, en;
        logic [1:0] md;
        c  = (din & ~force_en) | (force_val & force_en);   // R1
        t0 = grp_dec[0] ? (c[3:0] == 4'hF) : !comb_or;     // R6, R7
        t1 = grp_dec[1] ? (c[7:4] == 4'hF) : !comb_or;
        t2 = grp_dec[2] ? (c[9:8] == 2'h3) : !comb_or;
        g  = comb_or ? (t0 | t1 | t2) : (t0 & t1 & t2);
        if (grp_dec == 3'b000 && const_en) dv = const_val;  // R9
        else dv = dec_inv ? !g : g;                          // R8
        e.data = c;
        e.dec  = dv;
        for (int n = 0; n < 2; n++) begin
            md = n ? oe_mode1 : oe_mode0;
            if (grp_dec[n]) en = 0;                          // R5
            else case (md)
                2'b00: en = 0;
                2'b01: en = tri_ctl;
                2'b10: en = !tri_ctl;
                default: en = dv;                            // R4
            endcase
            e.oe[n*4 +: 4] = {4{en}};
        end
        e.tag_data = td; e.tag_oe = to; e.tag_dec = tdc;
        return e;
    endfunction

    task automatic sweep(string td, string to, string tdc);
        for (int i = 0; i < 1024; i++) begin
            @(negedge clk);
            din = i[9:0];
            tri_ctl = i[0] ^ i[5];
            sb.push_back(model(td, to, tdc));
        end
    endtask

    task automatic set_cfg(logic [2:0] gd, logic [1:0] m0, logic [1:0] m1,
                           logic co, logic inv, logic ce, logic cv,
                           logic [9:0] fe, logic [9:0] fv);
        @(negedge clk);
        grp_dec = gd; oe_mode0 = m0; oe_mode1 = m1; comb_or = co;
        dec_inv = inv; const_en = ce; const_val = cv;
        force_en = fe; force_val = fv;
    endtask

    // Monitor: pops one expected item per clock once results appear
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                check(e.tag_data, "buf_out", 32'(buf_out), 32'(e.data));
                check(e.tag_oe,   "nib_oe",  32'(nib_oe),  32'(e.oe));
                check(e.tag_dec,  "dec_out", 32'(dec_out), 32'(e.dec));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        compared++; mismatched++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        din = 10'h3FF; tri_ctl = 1; const_en = 1; const_val = 1;
        repeat (3) @(negedge clk);
        // R10: outputs clear while reset is held
        check("R10", "buf_out", 32'(buf_out), 0);
        check("R10", "nib_oe",  32'(nib_oe),  0);
        check("R10", "dec_out", 32'(dec_out), 0);
        rst_n = 1;

        // R2/R3/R7: all buffers, neutral AND tree yields 1
        set_cfg(3'b000, 2'b01, 2'b10, 0, 0, 0, 0, '0, '0);
        sweep("R2", "R3", "R7");
        // R9 constant 0, R4 enable follows decode output
        set_cfg(3'b000, 2'b00, 2'b11, 0, 0, 1, 0, '0, '0);
        sweep("R2", "R4", "R9");
        // R6 full AND decode, R5 nibbles quiet despite pass mode
        set_cfg(3'b111, 2'b01, 2'b01, 0, 0, 0, 0, '0, '0);
        sweep("R2", "R5", "R6");
        // R8 inverted OR decode, const request ignored (R9)
        set_cfg(3'b111, 2'b10, 2'b11, 1, 1, 1, 1, '0, '0);
        sweep("R2", "R5", "R8");
        // R7 partial OR decode, other nibble enabled from decode (R4)
        set_cfg(3'b001, 2'b01, 2'b11, 1, 0, 1, 0, '0, '0);
        sweep("R2", "R4", "R7");
        // R1 forced bits into buffers and decode
        set_cfg(3'b110, 2'b10, 2'b00, 0, 0, 0, 0, 10'h3F0, 10'h2F0);
        sweep("R1", "R3", "R1");
        // R6 pair-only AND decode with inversion
        set_cfg(3'b100, 2'b11, 2'b01, 0, 1, 0, 1, '0, '0);
        sweep("R2", "R4", "R6");

        repeat (4) @(negedge clk);
        check("R2", "scoreboard drained", 32'(sb.size()), 0);
        finish_run();
    end
endmodule